// File: doc/BRIEF.md
# CPU Mode and Status Control Unit

This block keeps the processor status flags of a CPU core that has a 16-bit native mode and an 8-bit legacy compatibility mode. It also keeps a hidden mode bit, the stack pointer and the direct page register. The sequencer drives one command per clock. A command can set or clear flags through a mask, swap the mode bit with carry, load the stack pointer, push or pop it, or load the direct page register. In return the block reports the mode, the effective register widths, the packed status byte, the stack pointer and the direct page register.

Two outputs are purely combinational. The first is the direct-page indexed effective address. It wraps inside the direct page in compatibility mode and forms a plain 16-bit sum in native mode. The second is a pair of extra-cycle flags that the sequencer adds to instruction timing. When a swap moves the core into compatibility mode, a strobe tells the register file to clear the high bytes of the index registers on the same edge.

Top module: `cpu_mode_ctl`

## Requirements
- R1: When reset is asserted, the unit enters compatibility mode with the stack pointer at 0x01FF and the direct page at 0x0000. M and X both read as 1, and the status byte reads 0x24, which means only the interrupt-disable bit (bit 2) and the fixed bit 5 are set.
- R2: The mode bit changes only with the swap command (cmd=1). On that edge the mode bit takes the old carry (status bit 0) and carry takes the old mode bit. Set-flags (cmd=2) and clear-flags (cmd=3) never change the mode bit.
- R3: In compatibility mode, M and X read as 1. Mask bit 5 is ignored. Mask bit 4 sets or clears a break flag, which appears at status bit 4. Set and clear apply operand[7:0] as the mask.
- R4: In compatibility mode, the stack pointer high byte stays at 0x01. Load-SP (cmd=4) replaces only the low byte. Push (cmd=5, decrement) and pop (cmd=6, increment) wrap within page 0x01.
- R5: In native mode, load-SP, push and pop act on the full 16-bit stack pointer and wrap modulo 2^16.
- R6: The direct-page effective address is computed as follows. In native mode it is dp + offset + index, taken modulo 2^16. In compatibility mode it is {dp[15:8], (dp[7:0] + offset + index[7:0]) mod 256}.
- R7: Load-DP (cmd=7) loads all 16 bits of operand in both modes.
- R8: pg_extra is 1 only in compatibility mode, with ix_req high, when ix_base + ix_ofs lands in a different 256-byte page than ix_base.
- R9: int_extra is 1 only in native mode while irq_seq is high.
- R10: In native mode, status bit 5 is M and bit 4 is X. The layout is N,V,M,X,D,I,Z,C from bit 7 down to bit 0.
- R11: A swap that enters compatibility mode raises idx_hi_clr during that cycle. The same edge forces the stack pointer high byte to 0x01 and sets M and X.
- R12: A swap that enters native mode leaves M and X at 1 until a clear-flags command changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code (0 idle, 1 swap, 2 set flags, 3 clear flags, 4 load SP, 5 push, 6 pop, 7 load DP) |
| operand | input | 16 | Mask or load value |
| dp_off | input | 8 | Direct-page offset byte |
| dp_idx | input | 16 | Index register value for direct-page addressing |
| ix_base | input | 16 | Base address of an indexed access |
| ix_ofs | input | 16 | Index added to ix_base |
| ix_req | input | 1 | An indexed access is in progress |
| irq_seq | input | 1 | A break, software-interrupt or return-from-interrupt sequence is in progress |
| emu_mode | output | 1 | 1 = compatibility mode, 0 = native |
| m_flag | output | 1 | Effective accumulator width flag (1 = 8 bit) |
| x_flag | output | 1 | Effective index width flag (1 = 8 bit) |
| sp | output | 16 | Stack pointer |
| status | output | 8 | Packed status byte |
| dp_reg | output | 16 | Direct page register |
| dp_ea | output | 16 | Direct-page indexed effective address |
| idx_hi_clr | output | 1 | Clear the index high bytes on this edge |
| pg_extra | output | 1 | Add one cycle for a page crossing |
| int_extra | output | 1 | Add one cycle to the interrupt sequence |

## Verification
The bench builds the unit with its default parameters: a 16-bit data path, 8-bit pages, stack page 0x01 and a stack reset low byte of 0xFF. These values make every byte-wrap corner reachable with small vectors. Examples are a push from 0x0100, a load-SP of 0x0000 followed by a push, a direct-page sum that overflows 0xFF, and an index whose high byte must be dropped in compatibility mode. A table of effective-address vectors alternates between the two modes, so each swap direction is exercised many times.

// File: rtl/cpu_mode_pkg.sv
package cpu_mode_pkg;

   typedef enum logic [2:0] {
      CMD_IDLE = 3'd0,
      CMD_SWAP = 3'd1,
      CMD_SETF = 3'd2,
      CMD_CLRF = 3'd3,
      CMD_LDSP = 3'd4,
      CMD_PUSH = 3'd5,
      CMD_POP  = 3'd6,
      CMD_LDDP = 3'd7
   } mode_cmd_e;

   // Status byte bit positions
   localparam int SB_C  = 0;
   localparam int SB_Z  = 1;
   localparam int SB_I  = 2;
   localparam int SB_D  = 3;
   localparam int SB_XB = 4;
   localparam int SB_M  = 5;
   localparam int SB_V  = 6;
   localparam int SB_N  = 7;

   localparam int SB_W  = 8;

endpackage

// File: rtl/mode_flags.sv
module mode_flags
   import cpu_mode_pkg::*;
#(
   parameter logic [7:0] RST_FLAGS = 8'h34
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mode_cmd_e        cmd,
   input  logic [SB_W-1:0]  mask,
   output logic             emu,
   output logic             m_eff,
   output logic             x_eff,
   output logic             enter_emu,
   output logic [SB_W-1:0]  status
);

   logic [SB_W-1:0] flags_q;
   logic            brk_q;
   logic            emu_q;
   logic [SB_W-1:0] wmask;

   // Width flags are frozen while in compatibility mode
   assign wmask     = emu_q ? ~(SB_W'(1) << SB_M | SB_W'(1) << SB_XB) : '1;
   assign enter_emu = (cmd == CMD_SWAP) && flags_q[SB_C] && !emu_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         emu_q   <= 1'b1;
         flags_q <= RST_FLAGS;
         brk_q   <= 1'b0;
      end else begin
         case (cmd)
            CMD_SWAP: begin
               emu_q         <= flags_q[SB_C];
               flags_q[SB_C] <= emu_q;
               if (flags_q[SB_C]) begin
                  flags_q[SB_M]  <= 1'b1;
                  flags_q[SB_XB] <= 1'b1;
               end
            end
            CMD_SETF: begin
               flags_q <= flags_q | (mask & wmask);
               if (emu_q && mask[SB_XB]) brk_q <= 1'b1;
            end
            CMD_CLRF: begin
               flags_q <= flags_q & ~(mask & wmask);
               if (emu_q && mask[SB_XB]) brk_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign emu   = emu_q;
   assign m_eff = emu_q | flags_q[SB_M];
   assign x_eff = emu_q | flags_q[SB_XB];

   for (genvar b = 0; b < SB_W; b++) begin : g_sbit
      if (b == SB_M) begin : g_m
         assign status[b] = emu_q | flags_q[b];
      end else if (b == SB_XB) begin : g_xb
         assign status[b] = emu_q ? brk_q : flags_q[b];
      end else begin : g_plain
         assign status[b] = flags_q[b];
      end
   end

   p_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_SWAP |=> emu_q == $past(flags_q[SB_C]) && flags_q[SB_C] == $past(emu_q));

   p_mode_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(emu_q) |-> $past(cmd) == CMD_SWAP);

   p_width_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      emu_q |-> flags_q[SB_M] && flags_q[SB_XB]);

   p_native_entry_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_SWAP && emu_q && !flags_q[SB_C]) |=> flags_q[SB_M] && flags_q[SB_XB]);

endmodule

// File: rtl/stack_unit.sv
module stack_unit
   import cpu_mode_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int PAGE_W = 8,
   parameter logic [DATA_W-PAGE_W-1:0] EMU_PAGE = 'h01,
   parameter logic [PAGE_W-1:0]        RST_LO   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mode_cmd_e         cmd,
   input  logic [DATA_W-1:0] operand,
   input  logic              emu,
   input  logic              enter_emu,
   output logic [DATA_W-1:0] sp
);

   localparam int HI_W = DATA_W - PAGE_W;

   logic [DATA_W-1:0] sp_q, sp_d;
   logic [PAGE_W-1:0] lo_dec, lo_inc;

   assign lo_dec = sp_q[PAGE_W-1:0] - PAGE_W'(1);
   assign lo_inc = sp_q[PAGE_W-1:0] + PAGE_W'(1);

   always_comb begin
      sp_d = sp_q;
      case (cmd)
         CMD_SWAP: if (enter_emu) sp_d = {EMU_PAGE, sp_q[PAGE_W-1:0]};
         CMD_LDSP: sp_d = emu ? {EMU_PAGE, operand[PAGE_W-1:0]} : operand;
         CMD_PUSH: sp_d = emu ? {EMU_PAGE, lo_dec} : sp_q - DATA_W'(1);
         CMD_POP:  sp_d = emu ? {EMU_PAGE, lo_inc} : sp_q + DATA_W'(1);
         default:  ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sp_q <= {EMU_PAGE, RST_LO};
      else        sp_q <= sp_d;
   end

   assign sp = sp_q;

   p_sp_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
      emu |-> sp_q[DATA_W-1:PAGE_W] == EMU_PAGE);

   p_native_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PUSH && !emu) |=> sp_q == $past(sp_q) - DATA_W'(1));

   initial begin
      if (HI_W < 1) $display("stack_unit: page width must be below data width");
   end

endmodule

// File: rtl/dp_addr_unit.sv
module dp_addr_unit
   import cpu_mode_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mode_cmd_e         cmd,
   input  logic [DATA_W-1:0] operand,
   input  logic              emu,
   input  logic [PAGE_W-1:0] dp_off,
   input  logic [DATA_W-1:0] dp_idx,
   output logic [DATA_W-1:0] dp_reg,
   output logic [DATA_W-1:0] dp_ea
);

   logic [DATA_W-1:0] dp_q;
   logic [DATA_W-1:0] wide_sum;
   logic [PAGE_W-1:0] page_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                dp_q <= '0;
      else if (cmd == CMD_LDDP)  dp_q <= operand;
   end

   assign wide_sum = dp_q + DATA_W'(dp_off) + dp_idx;
   assign page_sum = dp_q[PAGE_W-1:0] + dp_off + dp_idx[PAGE_W-1:0];
   assign dp_ea    = emu ? {dp_q[DATA_W-1:PAGE_W], page_sum} : wide_sum;
   assign dp_reg   = dp_q;

   p_dp_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_LDDP |=> dp_q == $past(operand));

   p_dp_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      emu |-> dp_ea[DATA_W-1:PAGE_W] == dp_reg[DATA_W-1:PAGE_W]);

endmodule

// File: rtl/cycle_penalty.sv
module cycle_penalty #(
   parameter int DATA_W = 16,
   parameter int PAGE_W = 8
) (
   input  logic              emu,
   input  logic [DATA_W-1:0] ix_base,
   input  logic [DATA_W-1:0] ix_ofs,
   input  logic              ix_req,
   input  logic              irq_seq,
   output logic              pg_extra,
   output logic              int_extra
);

   logic [DATA_W-1:0] ix_sum;
   logic              crossed;

   assign ix_sum    = ix_base + ix_ofs;
   assign crossed   = ix_sum[DATA_W-1:PAGE_W] != ix_base[DATA_W-1:PAGE_W];
   assign pg_extra  = emu && ix_req && crossed;
   assign int_extra = !emu && irq_seq;

endmodule

// File: rtl/cpu_mode_ctl.sv
module cpu_mode_ctl
   import cpu_mode_pkg::*;
#(
   parameter int                       DATA_W   = 16,
   parameter int                       PAGE_W   = 8,
   parameter logic [DATA_W-PAGE_W-1:0] EMU_PAGE = 'h01,
   parameter logic [PAGE_W-1:0]        RST_LO   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd,
   input  logic [DATA_W-1:0] operand,
   input  logic [PAGE_W-1:0] dp_off,
   input  logic [DATA_W-1:0] dp_idx,
   input  logic [DATA_W-1:0] ix_base,
   input  logic [DATA_W-1:0] ix_ofs,
   input  logic              ix_req,
   input  logic              irq_seq,
   output logic              emu_mode,
   output logic              m_flag,
   output logic              x_flag,
   output logic [DATA_W-1:0] sp,
   output logic [SB_W-1:0]   status,
   output logic [DATA_W-1:0] dp_reg,
   output logic [DATA_W-1:0] dp_ea,
   output logic              idx_hi_clr,
   output logic              pg_extra,
   output logic              int_extra
);

   if (PAGE_W != SB_W) begin : g_bad_page
      $error("cpu_mode_ctl: PAGE_W must equal the status byte width");
   end
   if (DATA_W != 2 * PAGE_W) begin : g_bad_data
      $error("cpu_mode_ctl: DATA_W must be twice PAGE_W");
   end

   mode_cmd_e cmd_i;
   logic      emu;
   logic      enter_emu;

   assign cmd_i = mode_cmd_e'(cmd);

   mode_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd_i),
      .mask      (operand[SB_W-1:0]),
      .emu       (emu),
      .m_eff     (m_flag),
      .x_eff     (x_flag),
      .enter_emu (enter_emu),
      .status    (status)
   );

   stack_unit #(
      .DATA_W   (DATA_W),
      .PAGE_W   (PAGE_W),
      .EMU_PAGE (EMU_PAGE),
      .RST_LO   (RST_LO)
   ) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd_i),
      .operand   (operand),
      .emu       (emu),
      .enter_emu (enter_emu),
      .sp        (sp)
   );

   dp_addr_unit #(
      .DATA_W (DATA_W),
      .PAGE_W (PAGE_W)
   ) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd_i),
      .operand (operand),
      .emu     (emu),
      .dp_off  (dp_off),
      .dp_idx  (dp_idx),
      .dp_reg  (dp_reg),
      .dp_ea   (dp_ea)
   );

   cycle_penalty #(
      .DATA_W (DATA_W),
      .PAGE_W (PAGE_W)
   ) u_pen (
      .emu       (emu),
      .ix_base   (ix_base),
      .ix_ofs    (ix_ofs),
      .ix_req    (ix_req),
      .irq_seq   (irq_seq),
      .pg_extra  (pg_extra),
      .int_extra (int_extra)
   );

   assign emu_mode   = emu;
   assign idx_hi_clr = enter_emu;

   p_enter_page_r11: assert property (@(posedge clk) disable iff (!rst_n)
      idx_hi_clr |=> emu_mode && sp[DATA_W-1:PAGE_W] == EMU_PAGE && m_flag && x_flag);

   p_native_int_r9: assert property (@(posedge clk) disable iff (!rst_n)
      emu_mode |-> !int_extra);

endmodule

// File: tb/sim_cpu_mode_ctl.sv
module sim_cpu_mode_ctl;
   import cpu_mode_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd = 3'd0;
   logic [15:0] operand = '0;
   logic [7:0]  dp_off = '0;
   logic [15:0] dp_idx = '0;
   logic [15:0] ix_base = '0;
   logic [15:0] ix_ofs = '0;
   logic        ix_req = 1'b0;
   logic        irq_seq = 1'b0;
   logic        emu_mode, m_flag, x_flag, idx_hi_clr, pg_extra, int_extra;
   logic [15:0] sp, dp_reg, dp_ea;
   logic [7:0]  status;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   cpu_mode_ctl u0 (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .operand(operand),
      .dp_off(dp_off), .dp_idx(dp_idx), .ix_base(ix_base), .ix_ofs(ix_ofs),
      .ix_req(ix_req), .irq_seq(irq_seq), .emu_mode(emu_mode),
      .m_flag(m_flag), .x_flag(x_flag), .sp(sp), .status(status),
      .dp_reg(dp_reg), .dp_ea(dp_ea), .idx_hi_clr(idx_hi_clr),
      .pg_extra(pg_extra), .int_extra(int_extra)
   );

   task automatic chk(input string what, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", what, got, exp);
      end
   endtask

   task automatic run(input mode_cmd_e c, input logic [15:0] op);
      @(negedge clk);
      cmd = c;
      operand = op;
      @(negedge clk);
      cmd = CMD_IDLE;
      #1;
   endtask

   // {mode, dp, off, idx, expected ea}
   localparam logic [56:0] EA_VEC [7] = '{
      {1'b0, 16'h12F0, 8'h20, 16'h0005, 16'h1315},
      {1'b1, 16'h12F0, 8'h20, 16'h0005, 16'h1215},
      {1'b0, 16'h0000, 8'hFF, 16'h00FF, 16'h01FE},
      {1'b1, 16'h0000, 8'hFF, 16'h0002, 16'h0001},
      {1'b1, 16'h3400, 8'h10, 16'hFF00, 16'h3410},
      {1'b0, 16'h3400, 8'h10, 16'hFF00, 16'h3310},
      {1'b0, 16'hFFFF, 8'h01, 16'h0000, 16'h0000}
   };

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 emu", 16'(emu_mode), 16'h1);
      chk("R1 status", 16'(status), 16'h0024);
      chk("R1 sp", sp, 16'h01FF);
      chk("R1 dp", dp_reg, 16'h0000);
      chk("R1 m/x", {14'd0, m_flag, x_flag}, 16'h3);

      // R4 compatibility stack
      run(CMD_LDSP, 16'h1234);
      chk("R4 load low byte only", sp, 16'h0134);
      run(CMD_LDSP, 16'h0000);
      run(CMD_PUSH, 16'h0);
      chk("R4 push wraps in page", sp, 16'h01FF);
      run(CMD_POP, 16'h0);
      chk("R4 pop wraps in page", sp, 16'h0100);

      // R3 / R2 flag masks in compatibility mode
      run(CMD_SETF, 16'h0031);
      chk("R3 break and carry set, bit5 ignored", 16'(status), 16'h0035);
      chk("R2 set does not move mode", 16'(emu_mode), 16'h1);
      run(CMD_CLRF, 16'h0031);
      chk("R3 clear break, width flags stay", {6'd0, m_flag, x_flag, status}, 16'h0324);
      chk("R2 clear does not move mode", 16'(emu_mode), 16'h1);

      // R8 / R9 compatibility penalties
      ix_base = 16'h10F0; ix_ofs = 16'h0020; ix_req = 1'b1; irq_seq = 1'b1;
      #1;
      chk("R8 crossing in compat", 16'(pg_extra), 16'h1);
      chk("R9 no interrupt penalty in compat", 16'(int_extra), 16'h0);
      ix_base = 16'h1000; ix_ofs = 16'h0010;
      #1;
      chk("R8 no crossing", 16'(pg_extra), 16'h0);

      // R2 / R12 / R10 swap into native
      run(CMD_SWAP, 16'h0);
      chk("R2 swap to native", {14'd0, emu_mode, status[0]}, 16'h1);
      chk("R12 widths stay 8 bit", {14'd0, m_flag, x_flag}, 16'h3);
      chk("R10 native status layout", 16'(status), 16'h0035);
      run(CMD_CLRF, 16'h0030);
      chk("R10 M and X cleared", {6'd0, m_flag, x_flag, status}, 16'h0005);

      // R5 native stack
      run(CMD_LDSP, 16'h1234);
      run(CMD_PUSH, 16'h0);
      chk("R5 native push", sp, 16'h1233);
      run(CMD_LDSP, 16'h0000);
      run(CMD_PUSH, 16'h0);
      chk("R5 native push wraps", sp, 16'hFFFF);
      run(CMD_POP, 16'h0);
      chk("R5 native pop", sp, 16'h0000);

      // R8 / R9 native penalties
      ix_base = 16'h10F0; ix_ofs = 16'h0020;
      #1;
      chk("R8 no crossing penalty in native", 16'(pg_extra), 16'h0);
      chk("R9 interrupt penalty in native", 16'(int_extra), 16'h1);
      ix_req = 1'b0; irq_seq = 1'b0;

      // R7 native dp load
      run(CMD_LDDP, 16'h12F0);
      chk("R7 native dp load", dp_reg, 16'h12F0);

      // R11 enter compatibility (carry is 1)
      run(CMD_LDSP, 16'h2345);
      @(negedge clk);
      cmd = CMD_SWAP;
      #1;
      chk("R11 idx_hi_clr strobe", 16'(idx_hi_clr), 16'h1);
      @(negedge clk);
      cmd = CMD_IDLE;
      #1;
      chk("R11 sp page forced", sp, 16'h0145);
      chk("R11 mode and widths", {13'd0, emu_mode, m_flag, x_flag}, 16'h7);
      chk("R2 carry took old mode", 16'(status), 16'h0024);
      chk("R11 strobe drops", 16'(idx_hi_clr), 16'h0);

      run(CMD_LDDP, 16'hABCD);
      chk("R7 compat dp load", dp_reg, 16'hABCD);

      // R6 effective address table
      for (int i = 0; i < 7; i++) begin
         if (EA_VEC[i][56] != emu_mode) begin
            if (EA_VEC[i][56]) run(CMD_SETF, 16'h0001);
            else               run(CMD_CLRF, 16'h0001);
            run(CMD_SWAP, 16'h0);
         end
         run(CMD_LDDP, EA_VEC[i][55:40]);
         dp_off = EA_VEC[i][39:32];
         dp_idx = EA_VEC[i][31:16];
         #1;
         chk($sformatf("R6 ea vector %0d", i), dp_ea, EA_VEC[i][15:0]);
      end

      // R1 reset from native state
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 reset from native", {15'd0, emu_mode}, 16'h1);
      chk("R1 reset sp/dp", sp ^ dp_reg, 16'h01FF);
      chk("R1 reset status", 16'(status), 16'h0024);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule